// File: doc/BRIEF.md
# UART Transmitter with Shortened Final Stop Bit

This block serializes characters onto an asynchronous serial line. It runs off the system clock and advances only on a one-cycle enable, `tick`, that pulses sixteen times per bit period. Each character starts with a low start bit. The data bits follow least significant bit first, then an optional even-parity bit, then one or two stop bits. The final stop bit can be cut short in steps of one sixteenth of a bit. A wide range of settings can then keep pace with a receiver that resynchronizes on the next start edge.

Bytes enter through a valid/ready handshake. `in_ready` is high exactly when the transmitter is not sending. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. While a character or an idle character is on the line, `in_ready` stays low. The producer must then hold `in_valid` and `in_data` until the next edge with `in_ready` high. No byte is queued, so back-pressure lasts for the whole of one frame.

The `idle_req` input asks for an idle character, which is a frame-length stretch of marks. Idle characters are never shortened. The format inputs and the stop-fraction code may change at any time. They are captured only at the edge where a frame begins.

Top module: `uart_fracstop_tx`

## Requirements
- R1: While reset is asserted and directly after it, `txd` is 1, `busy` is 0 and `in_ready` is 1, whatever `in_valid` does.
- R2: `in_ready` equals the inverse of `busy`. A byte is accepted on an edge with `in_valid` and `in_ready` high, and `busy` is 1 from the next cycle until the frame ends.
- R3: A data frame begins with a start bit at 0. The data bits follow LSB first: 8 bits when `long_char` is 1, and the low 7 bits when it is 0. Every bit except the final stop bit lasts 16 ticks.
- R4: When `par_en` is 1, a parity bit comes right after the data bits. It makes the number of ones among the sent data bits plus parity even. When `par_en` is 0 there is no parity bit.
- R5: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two, all at 1. Of two stop bits, the first always lasts a full 16 ticks.
- R6: The final stop bit of a data frame lasts 9 + `stop_frac` ticks, so code 7 gives a full bit and code 0 gives 9/16.
- R7: Format inputs, `stop_frac` and `in_data` are sampled only at the accepting edge. Changing them during a frame does not alter it.
- R8: When `idle_req` is 1, `in_valid` is 0 and the block is free, an idle character is sent. It holds `txd` at 1 for 16 × (1 + data bits + parity bit + stop bits) ticks, whatever `stop_frac` is. When `in_valid` and `idle_req` are both high, the data byte wins.
- R9: Outside a frame `txd` is 1. `busy` falls on the edge that ends the last tick of the final stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable at 16 pulses per bit time |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Transmitter can take a byte |
| in_data | input | 8 | Byte to send |
| long_char | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en | input | 1 | Append an even-parity bit |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| stop_frac | input | 3 | Final stop length code, 9 + code ticks |
| idle_req | input | 1 | Request an idle character |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | A frame is on the line |

## Verification
The bench uses the default parameters: 8-bit data, 16 ticks per bit and a 3-bit fraction code. All 64 combinations of fraction code, character length, parity and stop count therefore fit in one sweep. The bench rebuilds every frame tick by tick from the requirements and compares it with the line. After each acceptance it scrambles every setting, to confirm that settings are captured at the start of a frame. The sweep is followed by idle characters under every fraction code, a priority case and edge data patterns.

// File: rtl/uft_pkg.sv
package uft_pkg;

  // What a loaded frame carries on the line.
  typedef enum logic {
    FRM_DATA = 1'b0,
    FRM_IDLE = 1'b1
  } frame_kind_e;

  // Frame format, captured together when a frame is loaded.
  typedef struct packed {
    logic two_stop;
    logic par_en;
    logic long_char;
  } frame_fmt_t;

endpackage

// File: rtl/uft_frame_pack.sv
module uft_frame_pack
  import uft_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  frame_fmt_t         fmt,
  input  frame_kind_e        kind,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);

  logic [CNT_W-1:0]  dlen;
  logic [DATA_W-1:0] masked;
  logic              parity;

  always_comb begin
    dlen   = fmt.long_char ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
    masked = data;
    if (!fmt.long_char) masked[DATA_W-1] = 1'b0;
    parity = ^masked;

    // Marks everywhere, then overlay start, data and parity for a data frame.
    frame = '1;
    if (kind == FRM_DATA) begin
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (i < int'(dlen)) frame[i+1] = data[i];
      end
      for (int j = 1; j < FRAME_W; j++) begin
        if (fmt.par_en && (j == int'(dlen) + 1)) frame[j] = parity;
      end
    end

    nbits = CNT_W'(1) + dlen + CNT_W'(fmt.par_en)
          + (fmt.two_stop ? CNT_W'(2) : CNT_W'(1));
  end

endmodule

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
  parameter int OVS   = 16,
  parameter int SUB_W = $clog2(OVS),
  parameter int LIM_W = $clog2(OVS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             bit_done
);

  logic [SUB_W-1:0] cnt;

  assign bit_done = run && tick && (LIM_W'(cnt) == limit - LIM_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (clear || bit_done) cnt <= '0;
    else if (run && tick)      cnt <= cnt + SUB_W'(1);
  end

endmodule

// File: rtl/uft_shifter.sv
module uft_shifter #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits,
  input  logic               advance,
  output logic               line,
  output logic               last_bit
);

  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '1;
      left <= '0;
    end else if (load) begin
      sreg <= frame_in;
      left <= nbits - CNT_W'(1);
    end else if (advance) begin
      sreg <= {1'b1, sreg[FRAME_W-1:1]};
      if (left != '0) left <= left - CNT_W'(1);
    end
  end

  assign line     = sreg[0];
  assign last_bit = (left == '0);

endmodule

// File: rtl/uart_fracstop_tx.sv
module uart_fracstop_tx
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              long_char,
  input  logic              par_en,
  input  logic              two_stop,
  input  logic [FRAC_W-1:0] stop_frac,
  input  logic              idle_req,
  output logic              txd,
  output logic              busy
);

  localparam int FRAME_W    = DATA_W + 4;
  localparam int CNT_W      = $clog2(FRAME_W + 1);
  localparam int LIM_W      = $clog2(OVS + 1);
  localparam int SHORT_BASE = OVS - (2 ** FRAC_W) + 1;

  logic              active;
  frame_kind_e       kind_q;
  logic [FRAC_W-1:0] frac_q;

  logic              take_data, take_idle, load;
  frame_kind_e       kind_now;
  frame_fmt_t        fmt_now;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]  nbits;
  logic [LIM_W-1:0]  limit;
  logic              bit_done, line, last_bit, frame_end;

  assign take_data = in_valid && !active;
  assign take_idle = idle_req && !in_valid && !active;
  assign load      = take_data || take_idle;
  assign kind_now  = take_data ? FRM_DATA : FRM_IDLE;
  assign fmt_now   = '{two_stop: two_stop, par_en: par_en, long_char: long_char};

  uft_frame_pack #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_pack (
    .data  (in_data),
    .fmt   (fmt_now),
    .kind  (kind_now),
    .frame (frame),
    .nbits (nbits)
  );

  // Only the final bit of a data frame takes the shortened length.
  assign limit = (last_bit && (kind_q == FRM_DATA))
               ? LIM_W'(SHORT_BASE) + LIM_W'(frac_q)
               : LIM_W'(OVS);

  uft_bit_timer #(.OVS(OVS), .LIM_W(LIM_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load),
    .run      (active),
    .tick     (tick),
    .limit    (limit),
    .bit_done (bit_done)
  );

  uft_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .frame_in (frame),
    .nbits    (nbits),
    .advance  (bit_done),
    .line     (line),
    .last_bit (last_bit)
  );

  assign frame_end = bit_done && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      kind_q <= FRM_DATA;
      frac_q <= '1;
    end else if (load) begin
      active <= 1'b1;
      kind_q <= kind_now;
      frac_q <= stop_frac;
    end else if (frame_end) begin
      active <= 1'b0;
    end
  end

  assign txd      = !active || line;
  assign busy     = active;
  assign in_ready = !active;

endmodule

// File: rtl/uft_checker.sv
module uft_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic in_valid,
  input logic in_ready,
  input logic idle_req,
  input logic txd,
  input logic busy
);

  // R2
  ready_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !busy);

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && !txd);

  // R8
  idle_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req && !in_valid && in_ready |=> busy && txd);

  // R9
  rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(txd) && busy);

  // R9
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));

endmodule

bind uart_fracstop_tx uft_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .idle_req (idle_req),
  .txd      (txd),
  .busy     (busy)
);

// File: tb/uart_fracstop_tx_test.sv
`timescale 1ns/1ps
module uart_fracstop_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       long_char = 1'b1;
  logic       par_en = 1'b0;
  logic       two_stop = 1'b0;
  logic [2:0] stop_frac = 3'd7;
  logic       idle_req = 1'b0;
  logic       txd;
  logic       busy;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  // Tick every other cycle, driven just after the rising edge.
  initial forever begin
    @(posedge clk);
    #1 tick = ~tick;
  end

  uart_fracstop_tx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .long_char(long_char),
    .par_en(par_en), .two_stop(two_stop), .stop_frac(stop_frac),
    .idle_req(idle_req), .txd(txd), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Send one frame and compare the line tick by tick with a model.
  task automatic run(input logic [7:0] d, input bit l, input bit p, input bit t,
                     input int f, input bit send, input bit idl, input string req);
    bit   bits[12];
    bit   ev[256];
    int   nb, total, dlen, len, n, mism, guard;
    logic [7:0] m;
    dlen = l ? 8 : 7;
    m = l ? d : {1'b0, d[6:0]};
    for (int i = 0; i < 12; i++) bits[i] = 1'b1;
    if (send) begin
      bits[0] = 1'b0;
      for (int i = 0; i < dlen; i++) bits[1+i] = d[i];
      if (p) bits[1+dlen] = ^m;
    end
    nb = 1 + dlen + (p ? 1 : 0) + (t ? 2 : 1);
    total = 0;
    for (int b = 0; b < nb; b++) begin
      len = (b == nb - 1 && send) ? 9 + f : 16;
      for (int k = 0; k < len; k++) begin
        ev[total] = bits[b];
        total++;
      end
    end
    in_data = d; long_char = l; par_en = p; two_stop = t;
    stop_frac = f[2:0]; in_valid = send; idle_req = idl;
    @(posedge clk);
    @(negedge clk);
    // Scramble every setting mid-frame (R7).
    in_valid = 1'b0; idle_req = 1'b0; in_data = ~d; long_char = ~l;
    par_en = ~p; two_stop = ~t; stop_frac = ~f[2:0];
    check(busy === 1'b1 && in_ready === 1'b0, "R2", "busy after accept",
          int'(busy), 1);
    n = 0; mism = 0; guard = 0;
    while (busy === 1'b1 && guard < 2000) begin
      if (tick) begin
        if (n < 256 && txd !== ev[n]) mism++;
        n++;
      end
      @(negedge clk);
      guard++;
    end
    check(mism == 0, send ? "R3 R4 R5" : "R8", "line pattern mismatches", mism, 0);
    check(n == total, send ? "R6 R5 R7" : "R8", "frame ticks", n, total);
    check(txd === 1'b1 && in_ready === 1'b1, "R9", "line at rest after frame",
          int'(txd), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    in_valid = 1'b1;  // ignored while in reset
    repeat (4) @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1",
          "state in reset", int'(busy), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1",
          "state after reset", int'(txd), 1);

    // Full sweep of fraction code, stop count, length and parity.
    for (int f = 0; f < 8; f++)
      for (int t = 0; t < 2; t++)
        for (int l = 0; l < 2; l++)
          for (int p = 0; p < 2; p++)
            run(8'(f * 37 + t * 91 + l * 13 + p * 55 + 8'hA5), l[0], p[0], t[0],
                f, 1'b1, 1'b0, "R6");

    // Idle characters are never shortened, under every code (R8).
    for (int f = 0; f < 8; f++)
      run(8'h00, f[0], f[1], f[2], f, 1'b0, 1'b1, "R8");

    // Data wins over a simultaneous idle request (R8).
    run(8'h3C, 1'b1, 1'b1, 1'b0, 2, 1'b1, 1'b1, "R8");
    // Edge data patterns: parity of all ones, dropped top bit in 7-bit mode (R4, R3).
    run(8'hFF, 1'b1, 1'b1, 1'b1, 0, 1'b1, 1'b0, "R4");
    run(8'h80, 1'b0, 1'b1, 1'b0, 7, 1'b1, 1'b0, "R3");
    run(8'h00, 1'b1, 1'b1, 1'b0, 0, 1'b1, 1'b0, "R4");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule